// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Halt Wakeup

This block chooses which of several maskable interrupt requests a small 8-bit core takes next. Each source carries a two-bit software priority code and a fixed hardware rank. Source index 0 has the highest rank and the last index has the lowest. The block tracks the core's current priority level. When it grants a request it raises that level to the level of the winning source, and it restores the earlier level from an internal stack when the return strobe arrives.

A mode input selects the preemption policy. In concurrent mode a routine that is running is never interrupted. In nested mode a request with a strictly higher level preempts it. While the core sleeps, the block produces a wakeup signal. In Wait any eligible request wakes the core. In Halt only sources marked halt-capable wake it, and the first grant after leaving Halt is restricted to those sources. If the stack overflows, the block does not stop working, but it raises a sticky debug flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source's two-bit code maps to a level as follows: 2'b11 gives 3, 2'b10 gives 0, 2'b01 gives 1 and 2'b00 gives 2. A pending source is eligible only if its level is strictly above cpu_level. cpu_level resets to 0.
- R2: Among eligible sources the highest level wins. A tie goes to the lowest source index.
- R3: A grant is made only while sleep_state is 2'b00 (run) and no earlier grant is still unacknowledged. On the next edge take_pulse is high for exactly one cycle and grant_idx shows the winner. grant_idx then stays unchanged until grant_ack.
- R4: On a grant, cpu_level becomes the granted source's level and the previous level is pushed onto the stack.
- R5: A cycle with rti_strobe high makes no grant. If the stack is not empty, it pops the saved level into cpu_level. If the stack is empty, cpu_level is left unchanged.
- R6: With nest_mode=0, no grant is made while the stack holds any entry.
- R7: With nest_mode=1, a request whose level is strictly above cpu_level preempts the running routine. A request at an equal level does not.
- R8: With sleep_state 2'b01 (wait), wake is high when any source is eligible. wake is low while sleep_state is run.
- R9: With sleep_state 2'b10 or 2'b11 (halt), wake is high only when an eligible source has its halt_ok bit set.
- R10: After Halt, the first grant goes to the best eligible halt-capable source. After that grant the halt filter is lifted, so a higher non-capable request is granted next.
- R11: A push onto a full stack sets stack_ovf, which stays set until reset. cpu_level is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pend | input | N_SRC | Pending request per source |
| prio_code | input | 2*N_SRC | Two-bit priority code per source, source i at bits [2i+1:2i] |
| halt_ok | input | N_SRC | Source may wake the core from Halt |
| nest_mode | input | 1 | 1 = nested preemption, 0 = concurrent |
| sleep_state | input | 2 | 00 run, 01 wait, 1x halt |
| rti_strobe | input | 1 | Return from interrupt, one cycle |
| grant_ack | input | 1 | Core accepted the current grant |
| grant_idx | output | IDX_W | Index of the granted source |
| take_pulse | output | 1 | One-cycle grant pulse |
| wake | output | 1 | Wakeup request to the sleeping core |
| cpu_level | output | 2 | Current core priority level |
| stack_ovf | output | 1 | Sticky level-stack overflow, debug only |

## Verification
A return strobe and a new higher-priority request can arrive in the same cycle. The bench provokes this in concurrent mode: it holds a level-3 request while a level-1 routine is running and then pulses rti_strobe. It then expects no take_pulse on that edge with cpu_level back at 0, followed by the grant on the next edge. A second overlap occurs on leaving Halt, when the halt filter and the priority decision act together. There the bench expects the halt-capable source first and the higher non-capable source right after the acknowledge.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;

   typedef logic [1:0] lvl_t;

   localparam logic [1:0] SLP_RUN  = 2'b00;
   localparam logic [1:0] SLP_WAIT = 2'b01;

   function automatic lvl_t code_to_level(input logic [1:0] code);
      lvl_t l;
      case (code)
         2'b11:   l = 2'd3;
         2'b10:   l = 2'd0;
         2'b01:   l = 2'd1;
         default: l = 2'd2;
      endcase
      return l;
   endfunction

   function automatic logic is_halted(input logic [1:0] st);
      return st[1];
   endfunction

endpackage

// File: rtl/irq_level_decode.sv
`timescale 1ns/1ps
module irq_level_decode
   import irq_prio_pkg::*;
#(
   parameter int N_SRC = 5
) (
   input  logic [2*N_SRC-1:0]      code_in,
   output logic [N_SRC-1:0][1:0]   lvl_out
);
   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign lvl_out[g] = code_to_level(code_in[2*g +: 2]);
   end
endmodule

// File: rtl/irq_rank_arbiter.sv
`timescale 1ns/1ps
module irq_rank_arbiter #(
   parameter int N_SRC = 5,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0]        elig,
   input  logic [N_SRC-1:0][1:0]   lvl,
   output logic                    found,
   output logic [IDX_W-1:0]        best_idx,
   output logic [1:0]              best_lvl
);
   // Scan from the lowest rank up; ">=" lets a lower index take a tie.
   always_comb begin
      found    = 1'b0;
      best_idx = '0;
      best_lvl = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (elig[i] && (!found || lvl[i] >= best_lvl)) begin
            found    = 1'b1;
            best_idx = IDX_W'(i);
            best_lvl = lvl[i];
         end
      end
   end
endmodule

// File: rtl/irq_level_stack.sv
`timescale 1ns/1ps
module irq_level_stack #(
   parameter int DEPTH = 5,
   parameter int WIDTH = 2,
   localparam int SP_W = $clog2(DEPTH + 1),
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic             empty,
   output logic             ovf
);
   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [SP_W-1:0]  sp_q;
   logic [SP_W-1:0]  top_ptr;
   logic             full;

   assign full     = (sp_q == SP_W'(DEPTH));
   assign empty    = (sp_q == '0);
   assign top_ptr  = sp_q - SP_W'(1);
   assign pop_data = mem_q[top_ptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
         ovf  <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (push) begin
         if (full) begin
            ovf <= 1'b1;
         end else begin
            mem_q[sp_q[AW-1:0]] <= push_data;
            sp_q <= sp_q + SP_W'(1);
         end
      end else if (pop && !empty) begin
         sp_q <= top_ptr;
      end
   end

   assert_no_pushpop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

   assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   assert_full_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> ovf);
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int N_SRC       = 5,
   parameter int STACK_DEPTH = N_SRC,
   parameter bit WAKE_REG    = 1'b0,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_SRC-1:0]     req_pend,
   input  logic [2*N_SRC-1:0]   prio_code,
   input  logic [N_SRC-1:0]     halt_ok,
   input  logic                 nest_mode,
   input  logic [1:0]           sleep_state,
   input  logic                 rti_strobe,
   input  logic                 grant_ack,
   output logic [IDX_W-1:0]     grant_idx,
   output logic                 take_pulse,
   output logic                 wake,
   output logic [1:0]           cpu_level,
   output logic                 stack_ovf
);
   if (N_SRC < 2) begin : g_bad_src
      $error("irq_prio_ctrl: N_SRC must be at least 2");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("irq_prio_ctrl: STACK_DEPTH must be at least 1");
   end

   logic [N_SRC-1:0][1:0] src_lvl;
   logic [N_SRC-1:0]      elig;
   logic [N_SRC-1:0]      elig_all;
   logic                  found;
   logic [IDX_W-1:0]      win_idx;
   logic [1:0]            win_lvl;
   lvl_t                  cur_level_q;
   logic                  ack_wait_q;
   logic                  post_halt_q;
   logic                  halt_filter;
   logic                  stk_empty;
   logic [1:0]            stk_top;
   logic                  fire;
   logic                  wake_c;

   irq_level_decode #(.N_SRC(N_SRC)) u_decode (
      .code_in (prio_code),
      .lvl_out (src_lvl)
   );

   assign halt_filter = is_halted(sleep_state) || post_halt_q;

   for (genvar g = 0; g < N_SRC; g++) begin : g_elig
      assign elig_all[g] = req_pend[g] && (src_lvl[g] > cur_level_q);
      assign elig[g]     = elig_all[g] && (!halt_filter || halt_ok[g]);
   end

   irq_rank_arbiter #(.N_SRC(N_SRC)) u_arb (
      .elig     (elig),
      .lvl      (src_lvl),
      .found    (found),
      .best_idx (win_idx),
      .best_lvl (win_lvl)
   );

   assign fire = found && (sleep_state == SLP_RUN) && !ack_wait_q &&
                 !rti_strobe && (nest_mode || stk_empty);

   irq_level_stack #(.DEPTH(STACK_DEPTH), .WIDTH(2)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fire),
      .push_data (cur_level_q),
      .pop       (rti_strobe),
      .pop_data  (stk_top),
      .empty     (stk_empty),
      .ovf       (stack_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_level_q <= 2'd0;
         ack_wait_q  <= 1'b0;
         take_pulse  <= 1'b0;
         grant_idx   <= '0;
         post_halt_q <= 1'b0;
      end else begin
         take_pulse <= fire;
         if (fire) begin
            grant_idx   <= win_idx;
            cur_level_q <= win_lvl;
            ack_wait_q  <= 1'b1;
         end else begin
            if (grant_ack) ack_wait_q <= 1'b0;
            if (rti_strobe && !stk_empty) cur_level_q <= stk_top;
         end
         if (is_halted(sleep_state)) post_halt_q <= 1'b1;
         else if (fire)              post_halt_q <= 1'b0;
      end
   end

   assign cpu_level = cur_level_q;

   always_comb begin
      if (sleep_state == SLP_WAIT)     wake_c = |elig_all;
      else if (is_halted(sleep_state)) wake_c = |(elig_all & halt_ok);
      else                             wake_c = 1'b0;
   end

   if (WAKE_REG) begin : g_wake_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wake <= 1'b0;
         else        wake <= wake_c;
      end
   end else begin : g_wake_comb
      assign wake = wake_c;

      assert_halt_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (is_halted(sleep_state) && wake) |-> (|(req_pend & halt_ok)));

      assert_run_nowake_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (sleep_state == SLP_RUN) |-> !wake);
   end

   assert_take_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_pulse |=> !take_pulse);

   assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wait_q && !grant_ack) |=> $stable(grant_idx));

   assert_run_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_state != SLP_RUN) |=> !take_pulse);

   assert_level_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take_pulse |-> (cur_level_q > $past(cur_level_q)));

   assert_rti_nogrant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rti_strobe |=> !take_pulse);

   assert_concurrent_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!nest_mode && !stk_empty) |=> !take_pulse);

   assert_halt_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take_pulse && $past(post_halt_q)) |->
         (|($past(halt_ok) & (N_SRC'(1) << grant_idx))));
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
   localparam int N  = 5;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req_pend = '0;
   logic [2*N-1:0] prio_code = '0;
   logic [N-1:0]  halt_ok = '0;
   logic          nest_mode = 1'b0;
   logic [1:0]    sleep_state = 2'b00;
   logic          rti_strobe = 1'b0;
   logic          grant_ack = 1'b0;
   logic [IW-1:0] grant_idx;
   logic          take_pulse;
   logic          wake;
   logic [1:0]    cpu_level;
   logic          stack_ovf;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   irq_prio_ctrl #(.N_SRC(N), .STACK_DEPTH(2)) uut (
      .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .prio_code(prio_code),
      .halt_ok(halt_ok), .nest_mode(nest_mode), .sleep_state(sleep_state),
      .rti_strobe(rti_strobe), .grant_ack(grant_ack), .grant_idx(grant_idx),
      .take_pulse(take_pulse), .wake(wake), .cpu_level(cpu_level),
      .stack_ovf(stack_ovf)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [1:0] lv2code(input int l);
      case (l)
         0: return 2'b10;
         1: return 2'b01;
         2: return 2'b00;
         default: return 2'b11;
      endcase
   endfunction

   task automatic set_lvl(input int i, input int l);
      prio_code[2*i +: 2] = lv2code(l);
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic restart;
      rst_n = 1'b0;
      req_pend = '0; halt_ok = '0; nest_mode = 1'b0; sleep_state = 2'b00;
      rti_strobe = 1'b0; grant_ack = 1'b0;
      for (int i = 0; i < N; i++) set_lvl(i, 0);
      tick; tick;
      rst_n = 1'b1;
      tick;
   endtask

   task automatic do_ack;
      grant_ack = 1'b1;
      tick;
      grant_ack = 1'b0;
   endtask

   task automatic t_reset;
      restart;
      chk("R3", "take after reset", int'(take_pulse), 0);
      chk("R1", "level after reset", int'(cpu_level), 0);
      chk("R8", "wake after reset", int'(wake), 0);
      chk("R11", "ovf after reset", int'(stack_ovf), 0);
   endtask

   task automatic t_rank;
      restart;
      set_lvl(0, 1); set_lvl(1, 2); set_lvl(3, 2);
      req_pend = 5'b01011;
      #1;
      chk("R8", "wake in run", int'(wake), 0);
      tick;
      chk("R3", "take pulse", int'(take_pulse), 1);
      chk("R2", "tie to lower index", int'(grant_idx), 1);
      chk("R4", "level raised", int'(cpu_level), 2);
      tick;
      chk("R3", "pulse one cycle", int'(take_pulse), 0);
      chk("R3", "index held", int'(grant_idx), 1);
   endtask

   task automatic t_codes;
      restart;
      set_lvl(2, 0);
      req_pend = 5'b00100;
      tick;
      chk("R1", "level 0 not above 0", int'(take_pulse), 0);
      set_lvl(2, 3);
      tick;
      chk("R1", "code 11 granted", int'(take_pulse), 1);
      chk("R1", "code 11 is level 3", int'(cpu_level), 3);
   endtask

   task automatic t_concurrent;
      restart;
      set_lvl(4, 1); set_lvl(0, 3);
      req_pend = 5'b10000;
      tick;
      chk("R6", "first grant", int'(grant_idx), 4);
      req_pend = 5'b00000;
      do_ack;
      req_pend = 5'b00001;
      tick; tick;
      chk("R6", "no preempt in concurrent", int'(take_pulse), 0);
      chk("R6", "level kept", int'(cpu_level), 1);
      rti_strobe = 1'b1;
      tick;
      rti_strobe = 1'b0;
      chk("R5", "no grant with rti", int'(take_pulse), 0);
      chk("R5", "level popped", int'(cpu_level), 0);
      tick;
      chk("R6", "grant after rti", int'(take_pulse), 1);
      chk("R6", "grant index after rti", int'(grant_idx), 0);
      chk("R4", "level after rti grant", int'(cpu_level), 3);
   endtask

   task automatic t_nested;
      restart;
      nest_mode = 1'b1;
      set_lvl(3, 1); set_lvl(2, 1); set_lvl(1, 2);
      req_pend = 5'b01000;
      tick;
      chk("R7", "base grant", int'(grant_idx), 3);
      req_pend = 5'b00000;
      do_ack;
      req_pend = 5'b00100;
      tick;
      chk("R7", "equal level no preempt", int'(take_pulse), 0);
      req_pend = 5'b00110;
      tick;
      chk("R7", "higher preempts", int'(take_pulse), 1);
      chk("R7", "preempt index", int'(grant_idx), 1);
      chk("R4", "nested level", int'(cpu_level), 2);
      req_pend = 5'b00000;
      do_ack;
      rti_strobe = 1'b1;
      tick;
      chk("R5", "pop to 1", int'(cpu_level), 1);
      tick;
      chk("R5", "pop to 0", int'(cpu_level), 0);
      tick;
      chk("R5", "empty pop keeps level", int'(cpu_level), 0);
      rti_strobe = 1'b0;
      chk("R11", "no overflow at depth 2", int'(stack_ovf), 0);
   endtask

   task automatic t_wait;
      restart;
      set_lvl(2, 1); set_lvl(0, 0);
      sleep_state = 2'b01;
      req_pend = 5'b00001;
      #1;
      chk("R8", "ineligible no wake", int'(wake), 0);
      req_pend = 5'b00101;
      #1;
      chk("R8", "wait wake", int'(wake), 1);
      tick;
      chk("R3", "no grant while asleep", int'(take_pulse), 0);
      sleep_state = 2'b00;
      tick;
      chk("R3", "grant after wait", int'(take_pulse), 1);
      chk("R2", "wait grant index", int'(grant_idx), 2);
   endtask

   task automatic t_halt;
      restart;
      nest_mode = 1'b1;
      set_lvl(0, 3); set_lvl(4, 1);
      halt_ok = 5'b10000;
      sleep_state = 2'b10;
      req_pend = 5'b00001;
      #1;
      chk("R9", "non-capable no wake", int'(wake), 0);
      req_pend = 5'b10001;
      #1;
      chk("R9", "capable wakes", int'(wake), 1);
      tick;
      sleep_state = 2'b00;
      tick;
      chk("R10", "first grant taken", int'(take_pulse), 1);
      chk("R10", "first grant is capable", int'(grant_idx), 4);
      do_ack;
      tick;
      chk("R10", "second grant taken", int'(take_pulse), 1);
      chk("R10", "second grant higher source", int'(grant_idx), 0);
      chk("R10", "level after second", int'(cpu_level), 3);
   endtask

   task automatic t_overflow;
      restart;
      nest_mode = 1'b1;
      set_lvl(4, 1); set_lvl(3, 2); set_lvl(2, 3);
      req_pend = 5'b10000;
      tick;
      req_pend = 5'b00000;
      do_ack;
      req_pend = 5'b01000;
      tick;
      req_pend = 5'b00000;
      do_ack;
      chk("R11", "full but not over", int'(stack_ovf), 0);
      req_pend = 5'b00100;
      tick;
      chk("R11", "third grant", int'(take_pulse), 1);
      chk("R11", "overflow flagged", int'(stack_ovf), 1);
      chk("R11", "level still raised", int'(cpu_level), 3);
      req_pend = 5'b00000;
      tick;
      chk("R11", "overflow sticky", int'(stack_ovf), 1);
   endtask

   initial begin
      t_reset;
      t_rank;
      t_codes;
      t_concurrent;
      t_nested;
      t_wait;
      t_halt;
      t_overflow;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule